// File: doc/BRIEF.md
# Adjustable Divide-Ratio Pulse Generator

This block divides its clock by a ratio N and emits a single-cycle pulse once every N cycles. It comes out of reset with N = 8. Two control lines change N while the block runs. A falling edge on the speed-up line lowers N by one, which shortens the period and raises the output rate. A falling edge on the slow-down line raises N by one.

N stays between 1 and 16. A request that would push it past either limit is dropped. When N shrinks below the value the internal counter already holds, the counter restarts from zero instead of running on to a terminal value it can no longer reach. Both control lines are registered once inside the block before their falling edges are detected.

Top module: `rate_pulse_gen`

## Requirements
- R1: While rst_ni is low, pulse_o is low. The asynchronous reset sets the ratio to 8, clears the internal count and clears both control samples to 0.
- R2: After reset is released, with both control inputs held low, pulse_o first goes high after the seventh rising clock edge. It then repeats every 8 cycles.
- R3: The block sees a falling edge on speed_up_i when the previously registered sample is 1 and the newly registered sample is 0. At the next rising edge the ratio drops by one.
- R4: A falling edge on slow_down_i, detected the same way, raises the ratio by one at the next rising edge.
- R5: The ratio never leaves the range 1..16. A speed-up edge at ratio 1 and a slow-down edge at ratio 16 are ignored. At ratio 1, pulse_o is high on every cycle.
- R6: If falling edges on both control inputs are detected in the same cycle, the ratio is unchanged.
- R7: A control input that rises, or that is held high for any number of cycles, does not change the ratio.
- R8: If the count exceeds the new ratio minus one, pulse_o stays low for that cycle and the count returns to 0 at the next edge.
- R9: pulse_o is high for one cycle when the count equals the ratio minus one. The count then returns to 0, so the pulses are exactly ratio cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_up_i | input | 1 | Falling edge lowers the ratio by one |
| slow_down_i | input | 1 | Falling edge raises the ratio by one |
| pulse_o | output | 1 | Single-cycle pulse, once per ratio cycles |

## Verification
The ratio is moved in several ways:
- single edges, which show the step size and its direction;
- long bursts into both limits, which separate saturation from wraparound;
- a control line held high for many cycles, which separates edge detection from level detection;
- coincident edges on both lines, which test the cancel rule.

A run of fast speed-up edges while the counter climbs pulls the ratio below the count, which exercises the restart path. A behavioural model in the bench is compared with pulse_o on every cycle. Separate measurements of the pulse spacing confirm each ratio reached.

// File: rtl/rate_pulse_pkg.sv
package rate_pulse_pkg;
  localparam int NUM_CTRL = 2;
  localparam int CH_FAST  = 0;
  localparam int CH_SLOW  = 1;
endpackage

// File: rtl/ctrl_fall_detect.sv
module ctrl_fall_detect #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic samp_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        samp_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        samp_q <= lvl_i[g];
        prev_q <= samp_q;
      end
    end
    assign fall_o[g] = prev_q & ~samp_q;

    assert_no_back2back_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[g] |=> !fall_o[g]);
  end
endmodule

// File: rtl/ratio_step.sv
module ratio_step #(
  parameter int MAX_RATIO  = 16,
  parameter int INIT_RATIO = 8,
  parameter int RW         = $clog2(MAX_RATIO + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_i,
  input  logic          slow_i,
  output logic [RW-1:0] ratio_o
);
  localparam logic [RW-1:0] MAX_R  = RW'(MAX_RATIO);
  localparam logic [RW-1:0] INIT_R = RW'(INIT_RATIO);
  localparam logic [RW-1:0] ONE_R  = RW'(1);

  logic [RW-1:0] ratio_q, ratio_d;

  always_comb begin
    ratio_d = ratio_q;
    if (fast_i && !slow_i && ratio_q > ONE_R)      ratio_d = ratio_q - ONE_R;
    else if (slow_i && !fast_i && ratio_q < MAX_R) ratio_d = ratio_q + ONE_R;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ratio_q <= INIT_R;
    else         ratio_q <= ratio_d;
  end

  assign ratio_o = ratio_q;

  assert_ratio_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q >= ONE_R) && (ratio_q <= MAX_R));
  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_i && !slow_i && ratio_q > ONE_R) |=> (ratio_q == $past(ratio_q) - ONE_R));
  assert_step_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_i && !fast_i && ratio_q < MAX_R) |=> (ratio_q == $past(ratio_q) + ONE_R));
  assert_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_i && ratio_q == ONE_R) |=> (ratio_q == ONE_R));
  assert_both_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_i && slow_i) |=> $stable(ratio_q));
  assert_quiet_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_i && !slow_i) |=> $stable(ratio_q));
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int MAX_RATIO = 16,
  parameter int RW        = $clog2(MAX_RATIO + 1),
  parameter int CW        = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  output logic          pulse_o
);
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] term, cnt_ext;

  assign term    = ratio_i - RW'(1);
  assign cnt_ext = RW'(cnt_q);
  assign pulse_o = (cnt_ext == term);

  // overshoot after a shrink restarts without a pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_ext >= term) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CW'(1);
  end

  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (cnt_q == '0));
  assert_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && ratio_i > RW'(2)) |=> !pulse_o);
  assert_overshoot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ext > term) |=> (cnt_q == '0));
endmodule

// File: rtl/rate_pulse_gen.sv
module rate_pulse_gen
  import rate_pulse_pkg::*;
#(
  parameter int MAX_RATIO  = 16,
  parameter int INIT_RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic speed_up_i,
  input  logic slow_down_i,
  output logic pulse_o
);
  localparam int RW = $clog2(MAX_RATIO + 1);

  logic [NUM_CTRL-1:0] lvl, fall;
  logic [RW-1:0]       ratio;

  always_comb begin
    lvl          = '0;
    lvl[CH_FAST] = speed_up_i;
    lvl[CH_SLOW] = slow_down_i;
  end

  ctrl_fall_detect #(.N(NUM_CTRL)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .fall_o(fall));

  ratio_step #(.MAX_RATIO(MAX_RATIO), .INIT_RATIO(INIT_RATIO), .RW(RW)) u_ratio (
    .clk_i(clk_i), .rst_ni(rst_ni), .fast_i(fall[CH_FAST]),
    .slow_i(fall[CH_SLOW]), .ratio_o(ratio));

  period_counter #(.MAX_RATIO(MAX_RATIO), .RW(RW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio), .pulse_o(pulse_o));

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !pulse_o);
endmodule

// File: tb/rate_pulse_gen_tb_top.sv
module rate_pulse_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast = 1'b0;
  logic slow = 1'b0;
  logic pulse;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  rate_pulse_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .speed_up_i(fast),
    .slow_down_i(slow), .pulse_o(pulse));

  // behavioural reference
  int m_ratio = 8, m_cnt = 0, nr;
  bit m_fs = 0, m_fp = 0, m_ss = 0, m_sp = 0, ff, fsl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ratio = 8; m_cnt = 0; m_fs = 0; m_fp = 0; m_ss = 0; m_sp = 0;
    end else begin
      ff  = m_fp && !m_fs;
      fsl = m_sp && !m_ss;
      nr  = m_ratio;
      if (ff && !fsl && m_ratio > 1) nr = m_ratio - 1;
      else if (fsl && !ff && m_ratio < 16) nr = m_ratio + 1;
      if (m_cnt >= m_ratio - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_ratio = nr;
      m_fp = m_fs; m_fs = fast;
      m_sp = m_ss; m_ss = slow;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // lockstep compare
  always @(negedge clk) begin
    if (!done) check({tag, " lockstep"}, int'(pulse), (rst_n && (m_cnt == m_ratio - 1)) ? 1 : 0);
  end

  task automatic pulse_line(input bit which, input int hi, input int lo);
    @(negedge clk);
    if (which) slow = 1'b1; else fast = 1'b1;
    repeat (hi) @(negedge clk);
    if (which) slow = 1'b0; else fast = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    int guard = 0;
    @(negedge clk);
    while (!pulse && guard < 64) begin @(negedge clk); guard++; end
    do begin @(negedge clk); n++; end while (!pulse && n < 64);
    check({req, " period"}, n, exp);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    tag = "R1";
    repeat (4) @(negedge clk);
    check("R1 reset pulse", int'(pulse), 0);
    rst_n = 1'b1;
    tag = "R2";
    n = 0;
    do begin @(negedge clk); n++; end while (!pulse && n < 40);
    check("R2 first pulse edges", n, 7);
    measure("R2", 8);
    measure("R2", 8);

    tag = "R3";
    pulse_line(1'b0, 2, 4);
    measure("R3", 7);

    tag = "R4";
    repeat (3) pulse_line(1'b1, 1, 3);
    measure("R4", 10);

    tag = "R7";
    @(negedge clk); slow = 1'b1;
    repeat (5) @(negedge clk);
    measure("R7 held", 10);
    measure("R7 held", 10);
    tag = "R4";
    slow = 1'b0;
    repeat (4) @(negedge clk);
    measure("R4 release", 11);

    tag = "R5";
    repeat (20) pulse_line(1'b0, 1, 2);
    measure("R5 floor", 1);
    check("R5 every cycle", int'(pulse), 1);
    repeat (20) pulse_line(1'b1, 1, 2);
    measure("R5 ceiling", 16);

    tag = "R6";
    repeat (3) begin
      @(negedge clk); fast = 1'b1; slow = 1'b1;
      @(negedge clk); fast = 1'b0; slow = 1'b0;
      repeat (3) @(negedge clk);
    end
    measure("R6 both", 16);

    tag = "R8";
    while (!pulse) @(negedge clk);
    repeat (10) pulse_line(1'b0, 1, 0);
    repeat (4) @(negedge clk);
    tag = "R9";
    measure("R9 after shrink", 6);
    measure("R9", 6);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule